// File: doc/BRIEF.md
# Fan PWM Controller with Settling Interrupts

The block drives a cooling fan through a pulse-width-modulated output. The period is a fixed constant of the core. Software can read it, and it never reads as zero. The high time within each period comes from a register that software writes. A memory-mapped register port with 32-bit data gives access to four things: a run control that holds the core in reset while it is low, the high-time and period registers, and a four-source interrupt block with mask, pending and raw-source registers.

The duty can change from two sides. Software can write the high-time register. The core can also raise the high time by a fixed step when a temperature-increase input pulses. After either kind of change the core waits a programmable settling time, counted in clock cycles, and then flags a PWM-changed event. A separate tach block reports its error and new-measurement events to this core through two event inputs. The interrupt output stays high for as long as any pending source is unmasked.

Top module: `fan_pwm_ctrl`

## Requirements
- R1: After reset, the run bit is 0 and the mask reads 0xF (all sources masked). Pending reads 0 and the high time equals PERIOD. pwm_o and irq_o are low.
- R2: rdata_o shows the register at addr_i in the same cycle, with no valid needed. The addresses are 0x40 mask, 0x44 pending, 0x48 raw source, 0x80 run (bit 0), 0x84 high time and 0xC0 period. The period register reads PERIOD and ignores writes. Any other address reads 0.
- R3: While run bit 0 at 0x80 is 0, pwm_o is low and the PWM counter is held at 0. No event sets a pending bit, temperature requests do not change the high time, and any settling count in progress is cancelled.
- R4: While running, a counter steps 0..PERIOD-1 and wraps. pwm_o is high exactly while the counter is below the high time, so a high time of 0 gives constant low and a high time at or above PERIOD gives constant high.
- R5: A write to 0x84 while running starts a settling count. Pending bit 0 (PWM changed) is set at the SETTLE-th clock edge after the write edge.
- R6: A temperature_up_i pulse while running sets the high time to min(high time + STEP, PERIOD) on the next edge. It also sets pending bit 2 and starts a settling count.
- R7: If a software write to 0x84 and a temperature request fall in the same cycle, the written value is the one kept, and a single settling count starts.
- R8: A new duty change during a settling count restarts the count from SETTLE, so only one PWM-changed event follows.
- R9: The pending bits are: bit 0 PWM changed, bit 1 tach error (tach_err_i), bit 2 temperature increase, bit 3 new measurement (meas_done_i). Each bit stays set until a write at 0x44 with a 1 in that bit position. If an event arrives in the same cycle as the clear, the bit stays set.
- R10: The raw source register at 0x48 shows, in the same bit positions, the events present in the current cycle.
- R11: irq_o is high while any pending bit whose mask bit is 0 is set.
- R12: The high-time register keeps the low DW = clog2(PERIOD+1) bits of a write, and its upper bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access valid |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| temperature_up_i | input | 1 | Core duty-increase request pulse |
| tach_err_i | input | 1 | Tach error event |
| meas_done_i | input | 1 | Tach new-measurement event |
| pwm_o | output | 1 | Fan PWM drive |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds the block with PERIOD 10, SETTLE 20 and STEP 3. With a period of 10 a whole PWM cycle can be checked in ten cycles, and a 4-bit high-time field makes a truncating write of 0x1F land above the period. With a settling time of 20 cycles the PWM-changed event, and the restart of the count by a second change, can be timed exactly within a short run. With a step of 3, two requests reach saturation at the period from 4 and a third request shows that it holds there.

// File: rtl/fanpwm_pkg.sv
package fanpwm_pkg;
  localparam int NIRQ = 4;
  localparam int AW   = 8;
  localparam int DATW = 32;

  localparam logic [AW-1:0] A_MASK   = 8'h40;
  localparam logic [AW-1:0] A_PEND   = 8'h44;
  localparam logic [AW-1:0] A_SRC    = 8'h48;
  localparam logic [AW-1:0] A_RUN    = 8'h80;
  localparam logic [AW-1:0] A_WIDTH  = 8'h84;
  localparam logic [AW-1:0] A_PERIOD = 8'hC0;

  localparam int EV_PWM  = 0;
  localparam int EV_TACH = 1;
  localparam int EV_TEMP = 2;
  localparam int EV_MEAS = 3;
endpackage

// File: rtl/fan_regfile.sv
module fan_regfile
  import fanpwm_pkg::*;
#(
  parameter int PERIOD = 256,
  parameter int STEP   = 16,
  parameter int DW     = $clog2(PERIOD + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DATW-1:0] wdata_i,
  input  logic            temperature_up_i,
  output logic            run_o,
  output logic [DW-1:0]   width_o,
  output logic [NIRQ-1:0] mask_o,
  output logic [NIRQ-1:0] clr_o,
  output logic            change_o,
  output logic            temp_ev_o
);
  logic            run_q;
  logic [DW-1:0]   width_q;
  logic [NIRQ-1:0] mask_q;
  logic            wr, wr_run, wr_width, wr_mask, wr_pend;
  logic [DW:0]     sum;
  logic [DW-1:0]   stepped;

  assign wr       = req_i & we_i;
  assign wr_run   = wr & (addr_i == A_RUN);
  assign wr_width = wr & (addr_i == A_WIDTH);
  assign wr_mask  = wr & (addr_i == A_MASK);
  assign wr_pend  = wr & (addr_i == A_PEND);

  assign temp_ev_o = temperature_up_i & run_q;

  // saturating core step toward full speed
  assign sum     = {1'b0, width_q} + (DW+1)'(STEP);
  assign stepped = (sum > (DW+1)'(PERIOD)) ? DW'(PERIOD) : sum[DW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      width_q <= DW'(PERIOD);
      mask_q  <= '1;
    end else begin
      if (wr_run)  run_q  <= wdata_i[0];
      if (wr_mask) mask_q <= wdata_i[NIRQ-1:0];
      if (wr_width)       width_q <= wdata_i[DW-1:0];
      else if (temp_ev_o) width_q <= stepped;
    end
  end

  assign run_o    = run_q;
  assign width_o  = width_q;
  assign mask_o   = mask_q;
  assign clr_o    = wr_pend ? wdata_i[NIRQ-1:0] : '0;
  assign change_o = run_q & (wr_width | temperature_up_i);
endmodule

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen #(
  parameter int PERIOD = 256,
  parameter int DW     = $clog2(PERIOD + 1),
  parameter int CW     = $clog2(PERIOD)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [DW-1:0] width_i,
  output logic [CW-1:0] cnt_o,
  output logic          pwm_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (!run_i)                     cnt_q <= '0;
    else if (cnt_q == CW'(PERIOD - 1))   cnt_q <= '0;
    else                                 cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
  assign pwm_o = run_i & (DW'(cnt_q) < width_i);
endmodule

// File: rtl/fan_settle_timer.sv
module fan_settle_timer #(
  parameter int SETTLE = 250_000_000,
  parameter int TW     = $clog2(SETTLE + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic start_i,
  output logic done_o
);
  logic [TW-1:0] tmr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               tmr_q <= '0;
    else if (!run_i)           tmr_q <= '0;
    else if (start_i)          tmr_q <= TW'(SETTLE);
    else if (tmr_q != '0)      tmr_q <= tmr_q - 1'b1;
  end

  assign done_o = run_i & (tmr_q == TW'(1));
endmodule

// File: rtl/fan_irq_ctrl.sv
module fan_irq_ctrl
  import fanpwm_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NIRQ-1:0] ev_i,
  input  logic [NIRQ-1:0] clr_i,
  input  logic [NIRQ-1:0] mask_i,
  output logic [NIRQ-1:0] pend_o,
  output logic            irq_o
);
  logic [NIRQ-1:0] pend_q;

  for (genvar i = 0; i < NIRQ; i++) begin : g_bit
    // event wins over a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q[i] <= 1'b0;
      else         pend_q[i] <= (pend_q[i] & ~clr_i[i]) | ev_i[i];
    end
  end

  assign pend_o = pend_q;
  assign irq_o  = |(pend_q & ~mask_i);
endmodule

// File: rtl/fan_pwm_ctrl.sv
module fan_pwm_ctrl
  import fanpwm_pkg::*;
#(
  parameter int PERIOD = 256,
  parameter int SETTLE = 250_000_000,
  parameter int STEP   = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [7:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        temperature_up_i,
  input  logic        tach_err_i,
  input  logic        meas_done_i,
  output logic        pwm_o,
  output logic        irq_o
);
  localparam int DW = $clog2(PERIOD + 1);
  localparam int CW = $clog2(PERIOD);

  logic            run;
  logic [DW-1:0]   width;
  logic [NIRQ-1:0] mask, clr, pend, ev;
  logic [CW-1:0]   cnt;
  logic            change, temp_ev, settled;

  fan_regfile #(.PERIOD(PERIOD), .STEP(STEP), .DW(DW)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .temperature_up_i,
    .run_o(run), .width_o(width), .mask_o(mask), .clr_o(clr),
    .change_o(change), .temp_ev_o(temp_ev)
  );

  fan_pwm_gen #(.PERIOD(PERIOD), .DW(DW), .CW(CW)) u_pwm (
    .clk_i, .rst_ni, .run_i(run), .width_i(width), .cnt_o(cnt), .pwm_o
  );

  fan_settle_timer #(.SETTLE(SETTLE)) u_settle (
    .clk_i, .rst_ni, .run_i(run), .start_i(change), .done_o(settled)
  );

  always_comb begin
    ev          = '0;
    ev[EV_PWM]  = settled;
    ev[EV_TACH] = tach_err_i & run;
    ev[EV_TEMP] = temp_ev;
    ev[EV_MEAS] = meas_done_i & run;
  end

  fan_irq_ctrl u_irq (
    .clk_i, .rst_ni, .ev_i(ev), .clr_i(clr), .mask_i(mask),
    .pend_o(pend), .irq_o
  );

  always_comb begin
    case (addr_i)
      A_MASK:   rdata_o = 32'(mask);
      A_PEND:   rdata_o = 32'(pend);
      A_SRC:    rdata_o = 32'(ev);
      A_RUN:    rdata_o = 32'(run);
      A_WIDTH:  rdata_o = 32'(width);
      A_PERIOD: rdata_o = 32'(PERIOD);
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/fan_pwm_ctrl_chk.sv
module fan_pwm_ctrl_chk #(
  parameter int PERIOD = 256,
  parameter int DW     = $clog2(PERIOD + 1),
  parameter int CW     = $clog2(PERIOD)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          we_i,
  input logic [7:0]    addr_i,
  input logic [31:0]   wdata_i,
  input logic          temperature_up_i,
  input logic          tach_err_i,
  input logic          pwm_o,
  input logic          irq_o,
  input logic          run,
  input logic [DW-1:0] width,
  input logic [3:0]    pend,
  input logic [CW-1:0] cnt
);
  logic wr_w, clr1, clr_all;
  assign wr_w    = req_i & we_i & (addr_i == 8'h84);
  assign clr1    = req_i & we_i & (addr_i == 8'h44) & wdata_i[1];
  assign clr_all = req_i & we_i & (addr_i == 8'h44) & (wdata_i[3:0] == 4'hF);

  assert_idle_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> !pwm_o);

  assert_cnt_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt) < PERIOD);

  assert_step_cap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (temperature_up_i && run && !wr_w && int'(width) <= PERIOD)
      |=> (int'(width) <= PERIOD && width >= $past(width)));

  assert_tach_sets_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tach_err_i && run) |=> pend[1]);

  assert_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend[1] && !clr1) |=> pend[1]);

  assert_clear_drops_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_all && !run) |=> (pend == 4'h0 && !irq_o));
endmodule

bind fan_pwm_ctrl fan_pwm_ctrl_chk #(.PERIOD(PERIOD)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .temperature_up_i(temperature_up_i),
  .tach_err_i(tach_err_i), .pwm_o(pwm_o), .irq_o(irq_o),
  .run(run), .width(width), .pend(pend), .cnt(cnt)
);

// File: tb/sim_fan_pwm_ctrl.sv
`timescale 1ns/1ps
module sim_fan_pwm_ctrl;
  localparam int P      = 10;
  localparam int SETTLE = 20;
  localparam int STEP   = 3;
  localparam int DWM    = 15; // low 4 bits kept

  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0, temp = 0, tach = 0, meas = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic pwm, irq;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  fan_pwm_ctrl #(.PERIOD(P), .SETTLE(SETTLE), .STEP(STEP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .temperature_up_i(temp),
    .tach_err_i(tach), .meas_done_i(meas), .pwm_o(pwm), .irq_o(irq)
  );

  // behavioural reference
  int m_run, m_width, m_mask, m_pend, m_timer, m_cnt;

  function automatic int m_src();
    int s = 0;
    if (m_run != 0) begin
      if (m_timer == 1) s |= 1;
      if (tach) s |= 2;
      if (temp) s |= 4;
      if (meas) s |= 8;
    end
    return s;
  endfunction

  function automatic int m_rd();
    case (addr)
      8'h40: return m_mask;
      8'h44: return m_pend;
      8'h48: return m_src();
      8'h80: return m_run;
      8'h84: return m_width;
      8'hC0: return P;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_width = P; m_mask = 15; m_pend = 0; m_timer = 0; m_cnt = 0;
    end else begin
      int ev, clr, n_run, n_width, n_mask, n_timer, n_cnt;
      bit wr, wr_w, chg;
      wr   = req && we;
      wr_w = wr && addr == 8'h84;
      ev   = m_src();
      clr  = (wr && addr == 8'h44) ? int'(wdata[3:0]) : 0;
      chg  = (m_run != 0) && (wr_w || temp);
      n_run = (wr && addr == 8'h80) ? int'(wdata[0]) : m_run;
      n_mask = (wr && addr == 8'h40) ? int'(wdata[3:0]) : m_mask;
      if (wr_w) n_width = int'(wdata) & DWM;
      else if (temp && m_run != 0) n_width = (m_width + STEP > P) ? P : m_width + STEP;
      else n_width = m_width;
      if (m_run == 0) n_timer = 0;
      else if (chg) n_timer = SETTLE;
      else if (m_timer != 0) n_timer = m_timer - 1;
      else n_timer = 0;
      n_cnt = (m_run == 0) ? 0 : ((m_cnt == P - 1) ? 0 : m_cnt + 1);
      m_pend = (m_pend & ~clr) | ev;
      m_run = n_run; m_mask = n_mask; m_width = n_width;
      m_timer = n_timer; m_cnt = n_cnt;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison, 5 ns before the rising edge
  initial begin
    forever begin
      @(negedge clk); #5;
      if (rst_n) begin
        chk("R4 pwm_o vs model", 32'(pwm), 32'((m_run != 0) && (m_cnt < m_width)));
        chk("R11 irq_o vs model", 32'(irq), 32'((m_pend & ~m_mask & 15) != 0));
        chk("R2 rdata_o vs model", rdata, 32'(m_rd()));
      end
    end
  end

  task automatic idle();
    req = 0; we = 0; temp = 0; tach = 0; meas = 0;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); idle(); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); idle();
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk); idle(); req = 1; addr = a;
    #5 chk(tag, rdata, exp);
  endtask

  task automatic pulse_temp();
    @(negedge clk); idle(); temp = 1;
    @(negedge clk); idle();
  endtask

  task automatic wait_irq(output int k);
    k = 0; #5;
    while (!irq && k < 200) begin @(negedge clk); #5; k++; end
  endtask

  initial begin
    int k, highs;
    #5000000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int k, highs;
    repeat (3) @(negedge clk);
    #5;
    chk("R1 pwm_o low", 32'(pwm), 0);
    chk("R1 irq_o low", 32'(irq), 0);
    rst_n = 1;
    rd(8'h40, 32'hF, "R1 mask all ones");
    rd(8'h44, 0, "R1 pending zero");
    rd(8'h84, P, "R1 width equals period");
    rd(8'h80, 0, "R1 run bit zero");
    rd(8'hC0, P, "R2 period");
    rd(8'h10, 0, "R2 unmapped");

    // R3: stopped core ignores events and requests
    pulse_temp();
    @(negedge clk); tach = 1; meas = 1; @(negedge clk); idle();
    rd(8'h44, 0, "R3 no pending while stopped");
    rd(8'h84, P, "R3 width unchanged while stopped");
    chk("R3 pwm low while stopped", 32'(pwm), 0);

    wr(8'hC0, 5);
    rd(8'hC0, P, "R2 period write ignored");

    wr(8'h80, 1);
    wr(8'h40, 0);
    // R5: settle timing after software write
    wr(8'h84, 4);
    wait_irq(k);
    chk("R5 settle cycles to pwm-changed", k, SETTLE);
    rd(8'h44, 1, "R5 pending bit0");
    wr(8'h44, 1);
    rd(8'h44, 0, "R9 write-1 clear");

    // R4: duty over one period
    @(negedge clk); idle();
    highs = 0;
    for (int i = 0; i < P; i++) begin @(negedge clk); #5; if (pwm) highs++; end
    chk("R4 high cycles per period at width 4", highs, 4);

    // R6: core steps, saturating
    wr(8'h40, 4'hF);
    pulse_temp();
    rd(8'h84, 7, "R6 step to 7");
    rd(8'h44, 4, "R6 pending bit2");
    pulse_temp();
    rd(8'h84, P, "R6 saturate at period");
    pulse_temp();
    rd(8'h84, P, "R6 stays at period");

    // R7: same-cycle write and request
    @(negedge clk); idle(); req = 1; we = 1; addr = 8'h84; wdata = 2; temp = 1;
    @(negedge clk); idle();
    rd(8'h84, 2, "R7 software value wins");
    wr(8'h44, 4'hF);
    wr(8'h40, 4'hE);

    // R8: restart during settling
    wr(8'h84, 5);
    repeat (10) @(negedge clk);
    wr(8'h84, 6);
    wait_irq(k);
    chk("R8 restarted settle count", k, SETTLE);
    wr(8'h44, 1);
    repeat (SETTLE + 5) @(negedge clk);
    rd(8'h44, 0, "R8 single pwm-changed event");

    // R9: tach/meas events and clear collision
    wr(8'h40, 4'hF);
    @(negedge clk); idle(); tach = 1; meas = 1; @(negedge clk); idle();
    rd(8'h44, 32'hA, "R9 tach and meas pending");
    @(negedge clk); idle(); req = 1; we = 1; addr = 8'h44; wdata = 32'hA; tach = 1;
    @(negedge clk); idle();
    rd(8'h44, 2, "R9 event beats clear");

    // R11: masking
    rd(8'h40, 32'hF, "R11 mask readback");
    chk("R11 masked pending gives no irq", 32'(irq), 0);
    wr(8'h40, 4'hD);
    #5 chk("R11 unmasked pending raises irq", 32'(irq), 1);
    wr(8'h44, 4'hF);
    #5 chk("R11 irq drops after clear", 32'(irq), 0);

    // R10: live source
    @(negedge clk); idle(); meas = 1; req = 1; addr = 8'h48;
    #5 chk("R10 source shows meas", rdata, 8);
    @(negedge clk); idle(); tach = 1; req = 1; addr = 8'h48;
    #5 chk("R10 source shows tach", rdata, 2);
    @(negedge clk); idle();
    wr(8'h44, 4'hF);

    // R12: truncation and extremes
    wr(8'h84, 32'h1F);
    rd(8'h84, 32'hF, "R12 low bits kept");
    highs = 0;
    for (int i = 0; i < P; i++) begin @(negedge clk); #5; if (pwm) highs++; end
    chk("R4 constant high above period", highs, P);
    wr(8'h84, 0);
    highs = 0;
    for (int i = 0; i < P; i++) begin @(negedge clk); #5; if (pwm) highs++; end
    chk("R4 constant low at zero", highs, 0);

    // R3: stop cancels settle
    wr(8'h84, 3);
    wr(8'h80, 0);
    repeat (SETTLE + 5) @(negedge clk);
    rd(8'h44, 0, "R3 settle cancelled by stop");
    #1 chk("R3 pwm low after stop", 32'(pwm), 0);

    @(negedge clk); idle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule